// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-ups

An eight-pin general-purpose I/O port that a processor bus reaches through three register addresses. Each pin has a direction bit, a data bit and a synchronised input sample. The direction bit decides whether the pin is driven. The data bit gives the driven level on an output pin. On an input pin, the same data bit enables the internal pull-up instead. The block does not contain the pads. It drives per-pin output-enable, output-value and pull-up-enable signals into an external pad model, and it reads back the resolved pad levels.

Pad levels reach the bus through a two-stage synchroniser. The first stage is a latch that is open while the I/O clock is high. The second stage is a flop on the rising edge. A global pull-up disable turns off every pull-up at once. A sleep input forces the synchroniser input low, so that a floating pad does not toggle logic while the chip sleeps. The bus strobes are shared by all pins. Reads are combinational from the selected register.

Top module: `gpio_port`

## Requirements
- R1: An active-low reset clears the direction and data registers asynchronously, with no clock edge needed. After reset, oe_o, out_o and pu_o are all zero.
- R2: A write with addr_i = 0 loads wdata_i into the direction register at the rising clock edge. A read of address 0 returns the stored direction bits.
- R3: A write with addr_i = 1 loads wdata_i into the data register at the rising clock edge. A read of address 1 returns the stored data bits. The data register holds its value whenever no address-1 write occurs.
- R4: For each pin, oe_o equals its direction bit. out_o equals the data bit when the pin is an output, and is 0 when the pin is an input.
- R5: For each pin, pu_o is 1 only when all three hold: the data bit is 1, the direction bit is 0, and pull_dis_i is 0.
- R6: A read with addr_i = 2 returns the pad level that was present at the last falling clock edge, as captured by the following rising edge.
- R7: While sleep_i is 1, the synchroniser input is forced to 0. A read of address 2 then returns 0 for every pin, whatever the pad levels.
- R8: Writes to address 2 or 3 change neither the direction register nor the data register. A read of address 3 returns 0.
- R9: rdata_o is 0 whenever rd_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 direction, 1 data, 2 pin, 3 reserved |
| wr_en_i | input | 1 | Write strobe, shared by all pins |
| rd_en_i | input | 1 | Read strobe, shared by all pins |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pull_dis_i | input | 1 | Global pull-up disable |
| sleep_i | input | 1 | Sleep gate on the input path |
| pad_i | input | 8 | Resolved pad levels |
| oe_o | output | 8 | Per-pin output enable |
| out_o | output | 8 | Per-pin driven level |
| pu_o | output | 8 | Per-pin pull-up enable |

## Verification
A wrong direction bit or data bit shows on oe_o, out_o or pu_o in the cycle right after the write, with no extra delay. It also shows on the next read of that address. A fault in the synchroniser shows only on a read of address 2. That read reflects the pad after one falling edge and one rising edge, so a missing or extra stage shifts the result by one cycle. The bench therefore samples exactly at the second edge. It also sweeps every direction value against several data patterns with the pull-up disable both off and on.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ADR_DIR  = 2'd0,
    ADR_DATA = 2'd1,
    ADR_PIN  = 2'd2,
    ADR_RSVD = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  gpio_addr_e   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] data_o
);
  logic wr_dir, wr_data;
  assign wr_dir  = wr_en_i && (addr_i == ADR_DIR);
  assign wr_data = wr_en_i && (addr_i == ADR_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      data_o <= '0;
    end else begin
      if (wr_dir)  dir_o  <= wdata_i;
      if (wr_data) data_o <= wdata_i;
    end
  end

  p_dir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_DIR) |=> (dir_o == $past(wdata_i)));

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADR_DATA) |=> $stable(data_o));

  p_no_side_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1]) |=> ($stable(dir_o) && $stable(data_o)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] gated, lat_q;

  assign gated = sleep_i ? '0 : pad_i;

  // open while clock high, closes at falling edge
  always_latch begin
    if (clk_i) lat_q = gated;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_o <= '0;
    else         sync_o <= lat_q;
  end

  p_sleep_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sleep_i) && $past(rst_ni)) |-> (sync_o == '0));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] data_i,
  input  logic         pull_dis_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign oe_o[i]  = dir_i[i];
    assign out_o[i] = dir_i[i] & data_i[i];
    assign pu_o[i]  = data_i[i] & ~dir_i[i] & ~pull_dis_i;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         pull_dis_i,
  input  logic         sleep_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);
  gpio_addr_e   addr;
  logic [W-1:0] dir_q, data_q, pin_q;

  assign addr = gpio_addr_e'(addr_i);

  gpio_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr),
    .wdata_i(wdata_i), .dir_o(dir_q), .data_o(data_q)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i),
    .pad_i(pad_i), .sync_o(pin_q)
  );

  gpio_drive #(.W(W)) u_drive (
    .dir_i(dir_q), .data_i(data_q), .pull_dis_i(pull_dis_i),
    .oe_o(oe_o), .out_o(out_o), .pu_o(pu_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr)
        ADR_DIR:  rdata_o = dir_q;
        ADR_DATA: rdata_o = data_q;
        ADR_PIN:  rdata_o = pin_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  p_rst_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (oe_o == '0 && pu_o == '0 && out_o == '0));

  p_pu_not_on_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & oe_o) == '0);

  p_pu_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_dis_i |-> (pu_o == '0));

  p_read_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   addr = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wdata = '0, rdata;
  logic         pull_dis = 1'b0, sleep = 1'b0;
  logic [W-1:0] pad, oe, out, pu;
  logic [W-1:0] ext_en = '0, ext_val = '0;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  // pad: own driver, else external driver, else weak pull-up, else reads 0
  assign pad = (oe & out) | (~oe & ext_en & ext_val) | (~oe & ~ext_en & pu);

  gpio_port #(.W(W)) u_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .pull_dis_i(pull_dis), .sleep_i(sleep), .pad_i(pad),
    .oe_o(oe), .out_o(out), .pu_o(pu)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [W-1:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a; rd_en = 1'b1; #1;
    d = rdata;
    rd_en = 1'b0; #1;
  endtask

  task automatic read_pin(output logic [W-1:0] d);
    @(posedge clk); @(posedge clk); #2;
    bus_rd(2'd2, d);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    logic [W-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

    #5;
    chk("R1 oe in reset", oe, '0);
    chk("R1 pu in reset", pu, '0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    bus_rd(2'd0, r); chk("R1 dir after reset", r, '0);
    bus_rd(2'd1, r); chk("R1 data after reset", r, '0);

    // R2 R3 R4 R5 sweep: every direction value against several data patterns
    for (int p = 0; p < 4; p++) begin
      bus_wr(2'd1, pats[p]);
      for (int d = 0; d < 256; d++) begin
        bus_wr(2'd0, W'(d));
        for (int pd = 0; pd < 2; pd++) begin
          pull_dis = pd[0]; #1;
          chk("R4 oe", oe, W'(d));
          chk("R4 out", out, W'(d) & pats[p]);
          chk("R5 pu", pu, pd[0] ? '0 : (pats[p] & ~W'(d)));
        end
        pull_dis = 1'b0;
        bus_rd(2'd0, r); chk("R2 dir readback", r, W'(d));
        bus_rd(2'd1, r); chk("R3 data readback", r, pats[p]);
      end
    end

    // R8: writes to pin and reserved addresses are ignored
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'hFF);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, r); chk("R8 dir untouched", r, 8'h5A);
    bus_rd(2'd1, r); chk("R8 data untouched", r, 8'hC3);
    bus_rd(2'd3, r); chk("R8 reserved reads 0", r, '0);

    // R9: no read strobe, zero bus
    addr = 2'd1; #1; chk("R9 idle rdata", rdata, '0);

    // R6: all inputs, external driver, every pad value
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd1, 8'h00);
    ext_en = 8'hFF;
    for (int v = 0; v < 256; v++) begin
      ext_val = W'(v);
      read_pin(r); chk("R6 pin sample", r, W'(v));
    end
    // R6: one-cycle latency exactly; value changed just before falling edge visible after next rise
    ext_val = 8'h00; read_pin(r);
    @(posedge clk); #1 ext_val = 8'h96;
    #2 bus_rd(2'd2, r); chk("R6 not yet visible", r, 8'h00);
    @(posedge clk); #2 bus_rd(2'd2, r); chk("R6 visible after rise", r, 8'h96);

    // R6 with pull-ups and outputs: low nibble outputs, high nibble pulled up
    ext_en = '0;
    bus_wr(2'd1, 8'hF5);
    bus_wr(2'd0, 8'h0F);
    read_pin(r); chk("R6 mixed pad", r, 8'hF5);
    pull_dis = 1'b1;
    read_pin(r); chk("R5 pull-ups off", r, 8'h05);
    pull_dis = 1'b0;

    // R7: sleep gates input
    ext_en = 8'hFF; ext_val = 8'hFF; bus_wr(2'd0, 8'h00);
    @(posedge clk); #1 sleep = 1'b1;
    read_pin(r); chk("R7 sleep forces 0", r, '0);
    @(posedge clk); #1 sleep = 1'b0;
    read_pin(r); chk("R7 wake restores", r, 8'hFF);

    // R1: asynchronous reset mid-cycle, no edge needed
    ext_en = '0;
    bus_wr(2'd1, 8'hFF);
    bus_wr(2'd0, 8'hF0);
    #3 rst_n = 1'b0; #1;
    chk("R1 async oe", oe, '0);
    chk("R1 async pu", pu, '0);
    chk("R1 async out", out, '0);
    @(posedge clk); #1 rst_n = 1'b1;
    bus_rd(2'd1, r); chk("R1 data cleared", r, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule